// File: doc/BRIEF.md
# Trimmed 64-bit Time Base

This block keeps a 64-bit time value that grows by a small programmable step on every reference clock while counting is enabled. The rate can be trimmed in two ways. A one-shot budget of clocks can use an alternate step. A periodic trim replaces the normal step with the alternate step once every N clocks. Firmware programs a fractional rate by choosing N and the alternate step.

Two compare channels watch the time value. Each channel records a sticky flag the first time the value reaches or passes its 64-bit threshold. Channel 0 can also fold the time base back to zero. This turns the counter into a cyclic schedule timer whose period is the threshold plus one step.

All control goes through a 32-bit word register port. Reads return data one clock after the read strobe. Reading the low half of the time value freezes the high half for a later coherent read.

Top module: `trim_time_base`

## Requirements
- R1: After reset, every register reads as zero, including the time value, the configuration word, the overflow flag and the compare flags.
- R2: The configuration word at offset 0x00 holds the enable in bit 0, the normal step in bits 7:4 and the alternate step in bits 19:8. Other bits read as zero. While the enable is set, the time value grows by one step per clock. While it is clear, the time value holds.
- R3: Writes to offset 0x10 (low half) and offset 0x14 (high half) replace that half of the time value at the writing clock edge, and this takes priority over that clock's step. The 64-bit sum carries from the low half into the high half.
- R4: A read of offset 0x10 returns the low half and captures the high half. A following read of offset 0x14 returns the captured high half, even if the live value has changed since.
- R5: The one-shot trim budget at offset 0x08 (24 bits) makes each enabled clock use the alternate step while the budget is nonzero. The budget drops by one on each such clock, and reading 0x08 returns what remains.
- R6: A nonzero trim period N at offset 0x0C makes every N-th enabled clock use the alternate step, counted from the write of 0x0C. A value of 0 leaves the normal step in use.
- R7: Bit 0 of offset 0x04 is set when a step carries out of bit 63. It stays set until 1 is written to it.
- R8: Compare channel n is enabled by bit n+1 of offset 0x70. Its threshold is at 0x78+8n (low half) and 0x7C+8n (high half). Bit n of offset 0x74 is set when the time value first becomes greater than or equal to the threshold, and is cleared by writing 1. It does not set again while the value stays at or above the threshold.
- R9: With bit 0 of offset 0x70 and channel 0 both enabled, a time value at or above the channel-0 threshold is followed by 0 instead of the next step.
- R10: Read data appears on the clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the clock after regRe |

## Verification
The hardest situations to reach from the ports are those where a load, a carry or a wrap coincides with counting. The bench reaches them by writing the time value while counting is stopped, then running for an exact number of enabled clocks and stopping again. This places a carry out of bit 63, a cross of a compare threshold or a channel-0 wrap at a predictable step. It also issues a low-half write in the middle of an enabled run to show that the load overrides the step of that clock. Trim tests use a short period and a small budget, so that the expected sum of normal and alternate steps can be worked out by hand.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int WORD_W  = 32;
  localparam int COUNT_W = 2 * WORD_W;
  localparam int STEP_W  = 4;
  localparam int ALT_W   = 12;
  localparam int TRIM_W  = 24;
  localparam int CCFG_W  = 18;

  localparam int OFF_CFG      = 'h00;
  localparam int OFF_STAT     = 'h04;
  localparam int OFF_TRIM     = 'h08;
  localparam int OFF_PERIOD   = 'h0C;
  localparam int OFF_CNT_LO   = 'h10;
  localparam int OFF_CNT_HI   = 'h14;
  localparam int OFF_CMP_CFG  = 'h70;
  localparam int OFF_CMP_STAT = 'h74;
  localparam int OFF_CMP_BASE = 'h78;
  localparam int CMP_STRIDE   = 8;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadTrim;
    logic loadPeriod;
    logic clrOvf;
  } ttb_strobe_t;
endpackage

// File: rtl/ttb_ctrl.sv
module ttb_ctrl
  import ttb_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int NUM_CMP = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWe,
  input  logic                              regRe,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [WORD_W-1:0]                 regWdata,
  output logic [WORD_W-1:0]                 regRdata,
  input  logic [COUNT_W-1:0]                count,
  input  logic [TRIM_W-1:0]                 trimLeft,
  input  logic                              ovf,
  input  logic [NUM_CMP-1:0]                cmpStatus,
  output ttb_strobe_t                       strobe,
  output logic                              cntEn,
  output logic [STEP_W-1:0]                 stepNorm,
  output logic [ALT_W-1:0]                  stepAlt,
  output logic [WORD_W-1:0]                 trimPeriod,
  output logic                              wrapOnCmp0,
  output logic [NUM_CMP-1:0]                cmpEn,
  output logic [NUM_CMP-1:0][COUNT_W-1:0]   cmpVal,
  output logic [NUM_CMP-1:0]                cmpClr
);
  logic [CCFG_W-1:0] cmpCfgQ;
  logic [WORD_W-1:0] hiLatch;
  logic [WORD_W-1:0] rdNext;

  function automatic logic hitAddr(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strobe.loadLo     = regWe && hitAddr(regAddr, OFF_CNT_LO);
    strobe.loadHi     = regWe && hitAddr(regAddr, OFF_CNT_HI);
    strobe.loadTrim   = regWe && hitAddr(regAddr, OFF_TRIM);
    strobe.loadPeriod = regWe && hitAddr(regAddr, OFF_PERIOD);
    strobe.clrOvf     = regWe && hitAddr(regAddr, OFF_STAT) && regWdata[0];
    cmpClr = (regWe && hitAddr(regAddr, OFF_CMP_STAT)) ? regWdata[NUM_CMP-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn      <= 1'b0;
      stepNorm   <= '0;
      stepAlt    <= '0;
      trimPeriod <= '0;
      cmpCfgQ    <= '0;
    end else if (regWe) begin
      if (hitAddr(regAddr, OFF_CFG)) begin
        cntEn    <= regWdata[0];
        stepNorm <= regWdata[4 +: STEP_W];
        stepAlt  <= regWdata[8 +: ALT_W];
      end
      if (hitAddr(regAddr, OFF_PERIOD)) trimPeriod <= regWdata;
      if (hitAddr(regAddr, OFF_CMP_CFG)) cmpCfgQ <= regWdata[CCFG_W-1:0];
    end
  end

  assign wrapOnCmp0 = cmpCfgQ[0];
  assign cmpEn      = cmpCfgQ[NUM_CMP:1];

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_cmpReg
    localparam int LO_OFF = OFF_CMP_BASE + CMP_STRIDE * ch;
    logic [COUNT_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rstN) val <= '0;
      else if (regWe && hitAddr(regAddr, LO_OFF)) val[WORD_W-1:0] <= regWdata;
      else if (regWe && hitAddr(regAddr, LO_OFF + 4)) val[COUNT_W-1:WORD_W] <= regWdata;
    end
    assign cmpVal[ch] = val;
  end

  always_comb begin
    rdNext = '0;
    if (hitAddr(regAddr, OFF_CFG))
      rdNext = WORD_W'({stepAlt, stepNorm, 3'b000, cntEn});
    if (hitAddr(regAddr, OFF_STAT))     rdNext = WORD_W'(ovf);
    if (hitAddr(regAddr, OFF_TRIM))     rdNext = WORD_W'(trimLeft);
    if (hitAddr(regAddr, OFF_PERIOD))   rdNext = trimPeriod;
    if (hitAddr(regAddr, OFF_CNT_LO))   rdNext = count[WORD_W-1:0];
    if (hitAddr(regAddr, OFF_CNT_HI))   rdNext = hiLatch;
    if (hitAddr(regAddr, OFF_CMP_CFG))  rdNext = WORD_W'(cmpCfgQ);
    if (hitAddr(regAddr, OFF_CMP_STAT)) rdNext = WORD_W'(cmpStatus);
    for (int ch = 0; ch < NUM_CMP; ch++) begin
      if (hitAddr(regAddr, OFF_CMP_BASE + CMP_STRIDE * ch))
        rdNext = cmpVal[ch][WORD_W-1:0];
      if (hitAddr(regAddr, OFF_CMP_BASE + CMP_STRIDE * ch + 4))
        rdNext = cmpVal[ch][COUNT_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      hiLatch  <= '0;
    end else if (regRe) begin
      regRdata <= rdNext;
      if (hitAddr(regAddr, OFF_CNT_LO)) hiLatch <= count[COUNT_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/ttb_datapath.sv
module ttb_datapath
  import ttb_pkg::*;
#(
  parameter int NUM_CMP = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ttb_strobe_t                     strobe,
  input  logic [WORD_W-1:0]               wdata,
  input  logic                            cntEn,
  input  logic [STEP_W-1:0]               stepNorm,
  input  logic [ALT_W-1:0]                stepAlt,
  input  logic [WORD_W-1:0]               trimPeriod,
  input  logic                            wrapOnCmp0,
  input  logic [NUM_CMP-1:0]              cmpEn,
  input  logic [NUM_CMP-1:0][COUNT_W-1:0] cmpVal,
  input  logic [NUM_CMP-1:0]              cmpClr,
  output logic [COUNT_W-1:0]              count,
  output logic [TRIM_W-1:0]               trimLeft,
  output logic                            ovf,
  output logic [NUM_CMP-1:0]              cmpStatus
);
  logic [WORD_W-1:0]  periodTick;
  logic               periodDue;
  logic               useAlt;
  logic [COUNT_W-1:0] step;
  logic [COUNT_W:0]   sum;
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] hitPrev;
  logic               wrap;
  logic               anyLoad;

  assign periodDue = (trimPeriod != '0) && (periodTick == trimPeriod - 1'b1);
  assign useAlt    = (trimLeft != '0) || periodDue;
  assign step      = useAlt ? COUNT_W'(stepAlt) : COUNT_W'(stepNorm);
  assign sum       = {1'b0, count} + {1'b0, step};
  assign anyLoad   = strobe.loadLo || strobe.loadHi;

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_cmp
    assign hit[ch] = cmpEn[ch] && (count >= cmpVal[ch]);
  end
  assign wrap = wrapOnCmp0 && hit[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadLo) begin
      count[WORD_W-1:0] <= wdata;
    end else if (strobe.loadHi) begin
      count[COUNT_W-1:WORD_W] <= wdata;
    end else if (cntEn) begin
      count <= wrap ? '0 : sum[COUNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) trimLeft <= '0;
    else if (strobe.loadTrim) trimLeft <= wdata[TRIM_W-1:0];
    else if (cntEn && trimLeft != '0) trimLeft <= trimLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) periodTick <= '0;
    else if (strobe.loadPeriod) periodTick <= '0;
    else if (cntEn && trimPeriod != '0) periodTick <= periodDue ? '0 : periodTick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovf <= 1'b0;
    else if (cntEn && !anyLoad && !wrap && sum[COUNT_W]) ovf <= 1'b1;
    else if (strobe.clrOvf) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitPrev   <= '0;
      cmpStatus <= '0;
    end else begin
      hitPrev   <= hit;
      cmpStatus <= (cmpStatus & ~cmpClr) | (hit & ~hitPrev);
    end
  end
endmodule

// File: rtl/trim_time_base.sv
module trim_time_base
  import ttb_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int NUM_CMP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  ttb_strobe_t                     strobe;
  logic                            cntEn;
  logic [STEP_W-1:0]               stepNorm;
  logic [ALT_W-1:0]                stepAlt;
  logic [WORD_W-1:0]               trimPeriod;
  logic                            wrapOnCmp0;
  logic [NUM_CMP-1:0]              cmpEn;
  logic [NUM_CMP-1:0][COUNT_W-1:0] cmpVal;
  logic [NUM_CMP-1:0]              cmpClr;
  logic [COUNT_W-1:0]              count;
  logic [TRIM_W-1:0]               trimLeft;
  logic                            ovf;
  logic [NUM_CMP-1:0]              cmpStatus;

  ttb_ctrl #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .count(count), .trimLeft(trimLeft),
    .ovf(ovf), .cmpStatus(cmpStatus), .strobe(strobe), .cntEn(cntEn),
    .stepNorm(stepNorm), .stepAlt(stepAlt), .trimPeriod(trimPeriod),
    .wrapOnCmp0(wrapOnCmp0), .cmpEn(cmpEn), .cmpVal(cmpVal), .cmpClr(cmpClr)
  );

  ttb_datapath #(.NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata), .cntEn(cntEn),
    .stepNorm(stepNorm), .stepAlt(stepAlt), .trimPeriod(trimPeriod),
    .wrapOnCmp0(wrapOnCmp0), .cmpEn(cmpEn), .cmpVal(cmpVal), .cmpClr(cmpClr),
    .count(count), .trimLeft(trimLeft), .ovf(ovf), .cmpStatus(cmpStatus)
  );
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker
  import ttb_pkg::*;
#(
  parameter int NUM_CMP = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            regRe,
  input logic [WORD_W-1:0]               regRdata,
  input logic [WORD_W-1:0]               regWdata,
  input ttb_strobe_t                     strobe,
  input logic                            cntEn,
  input logic                            wrapOnCmp0,
  input logic [NUM_CMP-1:0]              cmpEn,
  input logic [NUM_CMP-1:0][COUNT_W-1:0] cmpVal,
  input logic [NUM_CMP-1:0]              cmpClr,
  input logic [NUM_CMP-1:0]              cmpStatus,
  input logic [COUNT_W-1:0]              count,
  input logic [TRIM_W-1:0]               trimLeft,
  input logic                            ovf
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !strobe.loadLo && !strobe.loadHi) |=> $stable(count)); // R2

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLo |=> (count[WORD_W-1:0] == $past(regWdata))); // R3

  AST_TRIM_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && trimLeft != '0 && !strobe.loadTrim) |=> (trimLeft == $past(trimLeft) - 1'b1)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobe.clrOvf) |=> ovf); // R7

  AST_CMP0_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStatus[0] && !cmpClr[0]) |=> cmpStatus[0]); // R8

  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && wrapOnCmp0 && cmpEn[0] && count >= cmpVal[0] && !strobe.loadLo && !strobe.loadHi)
      |=> (count == '0)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRe |=> $stable(regRdata)); // R10
endmodule

bind trim_time_base ttb_checker #(.NUM_CMP(NUM_CMP)) chk (
  .clk(clk), .rstN(rstN), .regRe(regRe), .regRdata(regRdata), .regWdata(regWdata),
  .strobe(strobe), .cntEn(cntEn), .wrapOnCmp0(wrapOnCmp0), .cmpEn(cmpEn),
  .cmpVal(cmpVal), .cmpClr(cmpClr), .cmpStatus(cmpStatus), .count(count),
  .trimLeft(trimLeft), .ovf(ovf)
);

// File: tb/trim_time_base_test.sv
`timescale 1ns/1ps
module trim_time_base_test;
  localparam int ADDR_W = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic              regRe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              rdIssued = 1'b0;
  logic              done = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  trim_time_base #(.ADDR_W(ADDR_W), .NUM_CMP(2)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  always @(posedge clk) rdIssued <= regRe;

  // monitor: pops the expected word for each completed read
  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10: read data with no expected item, actual %h", regRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (regRdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = ADDR_W'(addr); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [31:0] e, input string tag);
    @(negedge clk);
    regRe = 1'b1; regAddr = ADDR_W'(addr);
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  function automatic logic [31:0] cfgWord(input logic en, input logic [3:0] st, input logic [11:0] alt);
    return {12'h000, alt, st, 3'b000, en};
  endfunction

  // exactly n enabled clock edges (n >= 2)
  task automatic runCycles(input int n, input logic [3:0] st, input logic [11:0] alt);
    wr('h00, cfgWord(1'b1, st, alt));
    repeat (n - 2) @(negedge clk);
    wr('h00, cfgWord(1'b0, st, alt));
  endtask

  task automatic setCount(input logic [31:0] hi, input logic [31:0] lo);
    wr('h14, hi);
    wr('h10, lo);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd('h00, 32'h0, "R1 cfg");
    rd('h10, 32'h0, "R1 count low");
    rd('h04, 32'h0, "R1 overflow");
    rd('h74, 32'h0, "R1 compare status");

    // R2 field layout, unused bits read zero, R10 read path
    wr('h00, 32'hFFF0_0A40);
    rd('h00, 32'h0000_0A40, "R2 R10 cfg readback");

    // R2 basic stepping and hold
    runCycles(6, 4'd5, 12'd0);
    rd('h10, 32'd30, "R2 count after 6 steps of 5");
    repeat (5) @(negedge clk);
    rd('h10, 32'd30, "R2 count holds while disabled");

    // R4 coherent high read
    setCount(32'h1234_5678, 32'hFFFF_FFFF);
    rd('h10, 32'hFFFF_FFFF, "R4 low read");
    wr('h14, 32'h0);
    rd('h14, 32'h1234_5678, "R4 captured high");
    rd('h10, 32'hFFFF_FFFF, "R4 low reread");
    rd('h14, 32'h0, "R4 new high");

    // R3 carry into the high half
    setCount(32'h0, 32'hFFFF_FFFE);
    runCycles(3, 4'd1, 12'd0);
    rd('h10, 32'h1, "R3 carry low");
    rd('h14, 32'h1, "R3 carry high");

    // R3 load takes priority over the step of that clock
    setCount(32'h0, 32'h0);
    wr('h00, cfgWord(1'b1, 4'd3, 12'd0));
    wr('h10, 32'd100);
    wr('h00, cfgWord(1'b0, 4'd3, 12'd0));
    rd('h10, 32'd106, "R3 load overrides step");

    // R5 one-shot trim budget
    setCount(32'h0, 32'h0);
    wr('h08, 32'd3);
    rd('h08, 32'd3, "R5 budget readback");
    runCycles(5, 4'd4, 12'd10);
    rd('h10, 32'd38, "R5 three alternate steps then normal");
    rd('h08, 32'd0, "R5 budget used up");

    // R6 periodic trim
    setCount(32'h0, 32'h0);
    wr('h0C, 32'd4);
    runCycles(8, 4'd4, 12'd9);
    rd('h10, 32'd42, "R6 every fourth step alternate");
    wr('h0C, 32'd0);
    setCount(32'h0, 32'h0);
    runCycles(4, 4'd4, 12'd9);
    rd('h10, 32'd16, "R6 period zero uses normal step");

    // R7 overflow flag
    setCount(32'hFFFF_FFFF, 32'hFFFF_FFFE);
    runCycles(2, 4'd4, 12'd0);
    rd('h10, 32'd6, "R7 wrapped low");
    rd('h04, 32'h1, "R7 overflow set");
    wr('h04, 32'h1);
    rd('h04, 32'h0, "R7 overflow cleared");

    // R8 compare channel 1
    setCount(32'h0, 32'h0);
    wr('h80, 32'd20);
    wr('h84, 32'd0);
    wr('h70, 32'h4);
    runCycles(10, 4'd3, 12'd0);
    rd('h10, 32'd30, "R8 count past threshold");
    rd('h74, 32'h2, "R8 channel 1 flag only");
    wr('h74, 32'h2);
    repeat (3) @(negedge clk);
    rd('h74, 32'h0, "R8 flag stays clear above threshold");

    // R9 cycle mode
    wr('h70, 32'h0);
    setCount(32'h0, 32'h0);
    wr('h78, 32'd15);
    wr('h7C, 32'd0);
    wr('h74, 32'h3);
    wr('h70, 32'h3);
    runCycles(6, 4'd5, 12'd0);
    rd('h10, 32'd10, "R9 wrapped to zero after 15");
    rd('h14, 32'd0, "R9 high stays zero");
    rd('h74, 32'h1, "R8 R9 channel 0 flag");
    rd('h04, 32'h0, "R9 wrap is not overflow");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d reads unanswered, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule